// File: doc/BRIEF.md
# Down-counting reload PWM timer

This block is a 16-bit pulse-width generator. Its counter runs downward. While enable is high, the counter loads a programmed start value and steps down by one each clock. When it reaches zero, it reloads the start value on the following clock. One period therefore lasts start plus one clocks. The output is active from the reload down to the cycle before the count meets the match value. From the match value down to zero the output is inactive. An invert input swaps the active and inactive levels.

The block is meant to sit behind a register file that supplies the start value, match value, enable and invert settings. The start and match values are taken into use only when the counter loads or reloads. Software may therefore rewrite them at any time without damaging the period in progress. The output comes from a flip-flop that is updated together with the visible count.

Top module: `pwm_downtimer`

## Requirements
- R1: While enable is high and the counter is idle (after reset or after enable was low), the first clock loads `start_val` into `count`. Each later clock lowers `count` by one until it reads zero.
- R2: On the clock after `count` reads zero with enable still high, `count` becomes the start value again. A full period with a fixed start value S therefore spans S+1 clocks.
- R3: With `invert` = 0, `pwm_out` is 1 in every cycle whose `count` is strictly greater than the latched match value, and 0 otherwise. `pwm_out` and `count` are updated on the same clock edge. For start 0xC350 and match 0x411A, the output is high for 33334 of the 50001 clocks in a period.
- R4: With `invert` = 1, `pwm_out` is the complement of the R3 level. `invert` is taken on every clock, not only at reload.
- R5: While enable is low, `count` keeps its value and `pwm_out` shows the inactive level, which equals `invert`.
- R6: `start_val` and `match_val` are captured only on a load or reload clock. Changes made during a period do not alter the count sequence or the output until the next reload.
- R7: A match value greater than or equal to the start value keeps the uninverted output at 0 for the whole period. A match value of zero keeps it at 1 in every cycle except the one where `count` is zero.
- R8: A synchronous active-high `rst` sets `count` to zero and `pwm_out` to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| start_val | input | W (16) | Start value loaded at each reload |
| match_val | input | W (16) | Compare value; the output turns inactive at or below it |
| invert | input | 1 | Swaps the output polarity |
| pwm_out | output | 1 | Registered PWM output |
| count | output | W (16) | Current counter value |

## Verification
The hardest case to reach from the ports is a start or match value that changes partway through a period. The change must be held back until the reload. Only a reload that happens well after the write shows whether the hold worked. The random phase therefore keeps start values small, under 40, so that reloads occur every few dozen clocks. It also redraws start and match on every clock, so nearly every period sees new values arrive mid-count. A directed sequence rewrites both values a few cycles after a load and follows the count through the next reload. The full-size 0xC350/0x411A period is run once to measure the high time over the whole period.

// File: rtl/pwm_downtimer.sv
module pwm_downtimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] match_val,
  input  logic         invert,
  output logic         pwm_out,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, match_q;
  logic         run_q, pwm_q;

  wire         load    = en && (!run_q || cnt_q == '0);
  wire [W-1:0] cnt_d   = load ? start_val : cnt_q - W'(1);
  wire [W-1:0] match_d = load ? match_val : match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= '0;
      run_q   <= 1'b0;
      pwm_q   <= 1'b0;
    end else if (!en) begin
      run_q   <= 1'b0;
      pwm_q   <= invert;
    end else begin
      cnt_q   <= cnt_d;
      match_q <= match_d;
      run_q   <= 1'b1;
      pwm_q   <= (cnt_d > match_d) ^ invert;
    end
  end

  assign count   = cnt_q;
  assign pwm_out = pwm_q;

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (count == '0 && !pwm_out));

  p_first_load_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !run_q) |=> count == $past(start_val));

  p_decrement_r1: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && count != '0) |=> count == $past(count) - W'(1));

  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && count == '0) |=> count == $past(start_val));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (count == $past(count) && pwm_out == $past(invert)));

  p_match_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && count != '0) |=> match_q == $past(match_q));

endmodule

// File: tb/test_pwm_downtimer.sv
module test_pwm_downtimer;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst, en, invert;
  logic [W-1:0] start_val, match_val;
  logic         pwm_out;
  logic [W-1:0] count;

  int tests = 0, fails = 0;
  logic [W-1:0] m_cnt, m_match;
  logic         m_run, m_pwm;
  string        tag_force = "";
  bit           done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_downtimer #(.W(W)) i_pwm_downtimer (
    .clk(clk), .rst(rst), .en(en), .start_val(start_val),
    .match_val(match_val), .invert(invert), .pwm_out(pwm_out), .count(count)
  );

  function automatic bit exp_level(logic [W-1:0] c, logic [W-1:0] m, logic inv);
    return (c > m) ^ inv;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv, string what);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic step(logic r, logic e, logic [W-1:0] s, logic [W-1:0] m, logic inv);
    string tc, tp;
    rst = r; en = e; start_val = s; match_val = m; invert = inv;
    if (r) begin
      m_cnt = '0; m_match = '0; m_run = 0; m_pwm = 0; tc = "R8"; tp = "R8";
    end else if (!e) begin
      m_run = 0; m_pwm = inv; tc = "R5"; tp = "R5";
    end else begin
      if (!m_run || m_cnt == '0) begin
        tc = m_run ? "R2" : "R1";
        m_cnt = s; m_match = m;
      end else begin
        m_cnt = m_cnt - 1'b1; tc = "R1";
      end
      m_run = 1;
      m_pwm = exp_level(m_cnt, m_match, inv);
      tp = inv ? "R4" : "R3";
    end
    if (tag_force != "") begin tc = tag_force; tp = tag_force; end
    @(negedge clk);
    check(tc, count, m_cnt, "count");
    check(tp, W'(pwm_out), W'(m_pwm), "pwm_out");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));
    rst = 1; en = 0; invert = 0; start_val = '0; match_val = '0;
    m_cnt = '0; m_match = '0; m_run = 0; m_pwm = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 16'd5, 16'd2, 0);

    // R1, R2, R3: simple periods
    for (int i = 0; i < 25; i++) step(0, 1, 16'd7, 16'd3, 0);
    // R4: inverted, toggled live
    for (int i = 0; i < 20; i++) step(0, 1, 16'd7, 16'd3, (i % 6) > 2);
    // R5: hold while disabled, inactive level follows invert
    for (int i = 0; i < 6; i++) step(0, 0, 16'd9, 16'd1, i[0]);
    for (int i = 0; i < 12; i++) step(0, 1, 16'd9, 16'd1, 0);

    // R6: values rewritten mid-period stay out until reload
    tag_force = "R6";
    step(0, 0, 16'd10, 16'd4, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 16'd10, 16'd4, 0);
    for (int i = 0; i < 30; i++) step(0, 1, 16'd20, 16'd15, 0);

    // R7: match >= start, then match of zero
    tag_force = "R7";
    step(0, 0, 16'd20, 16'd30, 0);
    for (int i = 0; i < 45; i++) step(0, 1, 16'd20, 16'd30, 0);
    step(0, 0, 16'd20, 16'd20, 0);
    for (int i = 0; i < 45; i++) step(0, 1, 16'd20, 16'd20, 0);
    step(0, 0, 16'd12, 16'd0, 0);
    for (int i = 0; i < 30; i++) step(0, 1, 16'd12, 16'd0, 0);
    // R2: start of zero reloads every clock
    tag_force = "R2";
    step(0, 0, 16'd0, 16'd0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 16'd0, 16'd0, 0);
    tag_force = "";

    // R8: reset in the middle of a run
    for (int i = 0; i < 4; i++) step(0, 1, 16'd15, 16'd5, 0);
    step(1, 1, 16'd15, 16'd5, 0);

    // Random mix
    for (int i = 0; i < 4000; i++)
      step(($urandom % 200) == 0, ($urandom % 10) != 0,
           W'($urandom % 40), W'($urandom % 45), ($urandom % 50) == 0 ? ~invert : invert);

    // R3: full-size period duty
    step(0, 0, 16'hC350, 16'h411A, 0);
    highs = 0;
    for (int i = 0; i < 50001; i++) begin
      step(0, 1, 16'hC350, 16'h411A, 0);
      if (pwm_out) highs++;
    end
    check("R3", W'(highs), W'(33334), "high cycles per period");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule